// File: doc/BRIEF.md
# DMA Channel Trigger and Burst Sequencer

This block is the per-channel front end of a DMA controller. It decides when a channel is allowed to move data and how many transfers it may make in one go. A channel is started in one of three ways: a software pulse, a set-trigger pulse, or a hardware trigger input. The hardware trigger can be programmed as edge or level sensitive, and as active high or active low. Once a trigger is pending, the sequencer waits for two further conditions: an optional peripheral request and a valid descriptor. It then issues a one-cycle grant that carries a burst length. After that it waits for the transfer engine to report the burst as done.

Along with each grant the block hands the transfer engine three values taken from the configuration word: a source wrap flag, a destination wrap flag and the channel priority. With a wrap flag set, the engine returns the matching address to the start of the burst after every burst. With a burst size of one, source wrap and peripheral requests enabled, the channel reads one fixed source address again and again while the destination moves forward. Two status bits show the pending trigger and the valid-pending flag.

Top module: `dma_trig_seq`

## Requirements
- R1: While reset is held and on the cycle after it, `grant` is 0, `burst_len` is 0, `src_wrap`, `dst_wrap` and `prio` are 0, and `status` is 0.
- R2: A pulse on `sw_trig` or `set_trig` sets the trigger flag (`status` bit 2) on the next clock. If the sequencer is idle and the other conditions hold, `grant` rises one cycle later and stays high for exactly one cycle.
- R3: If configuration bit 6 is 1 (burst), `burst_len` equals 2 to the power min(n,10), where n is bits 11:8. If bit 6 is 0 (single), `burst_len` is 1. The value is a plain binary count.
- R4: At each grant, `src_wrap` takes configuration bit 14, `dst_wrap` takes bit 15 and `prio` takes bits 18:16. The three outputs then hold until the next grant, even if the configuration changes.
- R5: If configuration bit 0 is 1, no grant is issued while `periph_req` is low. The grant follows one cycle after `periph_req` goes high.
- R6: A grant needs `desc_valid` high or the valid-pending flag (`status` bit 0) set. A `set_valid` pulse sets that flag on the next clock, and the flag clears when a grant is issued.
- R7: The hardware trigger is used when configuration bit 1 is 1. In edge mode (bit 5 = 0), the input passes through two synchronizing flops. An edge of the polarity chosen by bit 4 (1 = rising, 0 = falling) sets the trigger flag three clocks after the input changes. An edge of the opposite polarity is ignored.
- R8: In level mode (bits 1 and 5 both 1), the trigger flag equals "input at its active level", with the same three-clock latency. A new grant follows each burst for as long as that level is held. The `sw_trig`, `set_trig` and `clr_trig` pulses have no effect on the flag in this mode.
- R9: In single mode, the trigger flag is consumed when `burst_done` completes the burst, so one trigger yields one grant. In burst mode the flag persists, and a new grant follows one cycle after `burst_done`.
- R10: The trigger flag is cleared by a `clr_trig` pulse, or by `desc_done` while `desc_clrtrig` is 1. `desc_done` with `desc_clrtrig` 0 leaves the flag set. If a set and a clear arrive in the same cycle, the set wins.
- R11: After a grant, no further grant is issued until `burst_done` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 19 | Channel configuration word (field positions as in R3 to R8) |
| periph_req | input | 1 | Peripheral request line |
| hw_trig | input | 1 | Asynchronous hardware trigger |
| sw_trig | input | 1 | Software trigger pulse |
| set_trig | input | 1 | Set-trigger pulse |
| clr_trig | input | 1 | Clear-trigger pulse |
| set_valid | input | 1 | Set valid-pending pulse |
| desc_valid | input | 1 | Current descriptor is valid |
| desc_done | input | 1 | Descriptor completion pulse |
| desc_clrtrig | input | 1 | Descriptor requests trigger clear at completion |
| burst_done | input | 1 | Transfer engine finished the granted burst |
| grant | output | 1 | One-cycle burst grant |
| burst_len | output | 11 | Transfers in the granted burst |
| src_wrap | output | 1 | Source wraps at burst end |
| dst_wrap | output | 1 | Destination wraps at burst end |
| prio | output | 3 | Channel priority, 0 highest |
| status | output | 3 | Bit 0 valid-pending, bit 2 trigger flag, bit 1 reads 0 |

## Verification
The hardest cases to reach from the ports are collisions inside the trigger flag. One is a set and a clear landing in the same cycle. Another is a single-mode trigger being consumed at the very edge where the sequencer returns to idle. The bench reaches them by driving pulses while a burst is still outstanding, because the flag can change there without starting a new grant. It also walks the hardware input through the synchronizer with opposite-polarity edges and level holds that span several bursts. Randomized configurations sweep burst powers above the limit, to check the clamp, together with wrap and priority fields that change while a burst is in flight.

// File: rtl/dma_trig_seq_pkg.sv
package dma_trig_seq_pkg;
  localparam int CFG_W  = 19;
  localparam int POW_W  = 4;
  localparam int PRIO_W = 3;

  typedef struct packed {
    logic              req_en;
    logic              hw_en;
    logic              pol_hi;
    logic              lvl_mode;
    logic              burst_mode;
    logic [POW_W-1:0]  pow;
    logic              src_wrap;
    logic              dst_wrap;
    logic [PRIO_W-1:0] prio;
  } chan_cfg_t;

  typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_state_t;

  function automatic chan_cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    chan_cfg_t c;
    c.req_en     = w[0];
    c.hw_en      = w[1];
    c.pol_hi     = w[4];
    c.lvl_mode   = w[5];
    c.burst_mode = w[6];
    c.pow        = w[11:8];
    c.src_wrap   = w[14];
    c.dst_wrap   = w[15];
    c.prio       = w[18:16];
    return c;
  endfunction
endpackage

// File: rtl/dma_trig_sync.sv
module dma_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise = lvl & ~last_q;
  assign fall = ~lvl & last_q;
endmodule

// File: rtl/dma_trig_flag.sv
module dma_trig_flag (
  input  logic clk,
  input  logic rst,
  input  logic hw_en,
  input  logic lvl_mode,
  input  logic pol_hi,
  input  logic sync_lvl,
  input  logic sync_rise,
  input  logic sync_fall,
  input  logic sw_set,
  input  logic clr_req,
  input  logic desc_done,
  input  logic desc_clrtrig,
  input  logic consume,
  output logic flag
);
  logic follow_level;
  logic hw_edge;
  logic set_any;
  logic clr_any;

  always_comb begin
    follow_level = hw_en & lvl_mode;
    hw_edge      = hw_en & ~lvl_mode & (pol_hi ? sync_rise : sync_fall);
    set_any      = hw_edge | sw_set;
    clr_any      = clr_req | (desc_done & desc_clrtrig) | consume;
  end

  // a set and a clear in the same cycle: the set is kept
  always_ff @(posedge clk) begin
    if (rst)               flag <= 1'b0;
    else if (follow_level) flag <= (sync_lvl == pol_hi);
    else if (set_any)      flag <= 1'b1;
    else if (clr_any)      flag <= 1'b0;
  end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_trig_seq_pkg::*;
#(
  parameter int MAX_POW = 10,
  parameter int LEN_W   = MAX_POW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  chan_cfg_t         cfg,
  input  logic              trig_flag,
  input  logic              periph_req,
  input  logic              desc_valid,
  input  logic              set_valid,
  input  logic              burst_done,
  output logic              grant,
  output logic [LEN_W-1:0]  burst_len,
  output logic              src_wrap,
  output logic              dst_wrap,
  output logic [PRIO_W-1:0] prio,
  output logic              valid_pend,
  output logic              consume
);
  seq_state_t       state;
  logic [POW_W-1:0] pow_eff;
  logic [LEN_W-1:0] len_next;
  logic             go;

  always_comb begin
    pow_eff  = (int'(cfg.pow) > MAX_POW) ? POW_W'(MAX_POW) : cfg.pow;
    len_next = cfg.burst_mode ? (LEN_W'(1) << pow_eff) : LEN_W'(1);
    go       = (state == SEQ_IDLE) & trig_flag &
               (~cfg.req_en | periph_req) & (desc_valid | valid_pend);
    consume  = (state == SEQ_BUSY) & burst_done &
               ~(cfg.hw_en & cfg.lvl_mode) & ~cfg.burst_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      grant      <= 1'b0;
      burst_len  <= '0;
      src_wrap   <= 1'b0;
      dst_wrap   <= 1'b0;
      prio       <= '0;
      valid_pend <= 1'b0;
    end else begin
      grant <= go;
      if (go) begin
        burst_len <= len_next;
        src_wrap  <= cfg.src_wrap;
        dst_wrap  <= cfg.dst_wrap;
        prio      <= cfg.prio;
      end
      if (set_valid) valid_pend <= 1'b1;
      else if (go)   valid_pend <= 1'b0;
      case (state)
        SEQ_IDLE: if (go)         state <= SEQ_BUSY;
        SEQ_BUSY: if (burst_done) state <= SEQ_IDLE;
        default:                  state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_trig_seq.sv
module dma_trig_seq
  import dma_trig_seq_pkg::*;
#(
  parameter int MAX_POW     = 10,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = MAX_POW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              periph_req,
  input  logic              hw_trig,
  input  logic              sw_trig,
  input  logic              set_trig,
  input  logic              clr_trig,
  input  logic              set_valid,
  input  logic              desc_valid,
  input  logic              desc_done,
  input  logic              desc_clrtrig,
  input  logic              burst_done,
  output logic              grant,
  output logic [LEN_W-1:0]  burst_len,
  output logic              src_wrap,
  output logic              dst_wrap,
  output logic [PRIO_W-1:0] prio,
  output logic [2:0]        status
);
  chan_cfg_t cfg;
  logic      s_lvl, s_rise, s_fall;
  logic      flag, vpend, consume;

  assign cfg = cfg_decode(cfg_word);

  dma_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(hw_trig),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  dma_trig_flag u_flag (
    .clk(clk), .rst(rst),
    .hw_en(cfg.hw_en), .lvl_mode(cfg.lvl_mode), .pol_hi(cfg.pol_hi),
    .sync_lvl(s_lvl), .sync_rise(s_rise), .sync_fall(s_fall),
    .sw_set(sw_trig | set_trig), .clr_req(clr_trig),
    .desc_done(desc_done), .desc_clrtrig(desc_clrtrig),
    .consume(consume), .flag(flag)
  );

  dma_burst_seq #(.MAX_POW(MAX_POW), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .cfg(cfg), .trig_flag(flag),
    .periph_req(periph_req), .desc_valid(desc_valid), .set_valid(set_valid),
    .burst_done(burst_done), .grant(grant), .burst_len(burst_len),
    .src_wrap(src_wrap), .dst_wrap(dst_wrap), .prio(prio),
    .valid_pend(vpend), .consume(consume)
  );

  assign status = {flag, 1'b0, vpend};
endmodule

// File: rtl/dma_trig_seq_chk.sv
module dma_trig_seq_chk #(
  parameter int MAX_POW = 10,
  parameter int LEN_W   = MAX_POW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_en,
  input logic             periph_req,
  input logic             desc_valid,
  input logic             set_valid,
  input logic             grant,
  input logic [LEN_W-1:0] burst_len,
  input logic [2:0]       status
);
  assert_grant_single_R11: assert property (@(posedge clk) disable iff (rst)
    grant |=> !grant);

  assert_len_pow2_R3: assert property (@(posedge clk) disable iff (rst)
    grant |-> ($countones(burst_len) == 1 && int'(burst_len) <= (1 << MAX_POW)));

  assert_req_gate_R5: assert property (@(posedge clk) disable iff (rst)
    grant |-> $past(periph_req | ~req_en));

  assert_valid_gate_R6: assert property (@(posedge clk) disable iff (rst)
    grant |-> $past(desc_valid | status[0]));

  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (grant && !$past(set_valid)) |-> !status[0]);

  assert_flag_first_R2: assert property (@(posedge clk) disable iff (rst)
    grant |-> $past(status[2]));
endmodule

bind dma_trig_seq dma_trig_seq_chk #(.MAX_POW(MAX_POW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .req_en(cfg_word[0]), .periph_req(periph_req),
  .desc_valid(desc_valid), .set_valid(set_valid), .grant(grant),
  .burst_len(burst_len), .status(status)
);

// File: tb/test_dma_trig_seq.sv
module test_dma_trig_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] cfg_word = '0;
  logic periph_req = 0, hw_trig = 0, sw_trig = 0, set_trig = 0, clr_trig = 0;
  logic set_valid = 0, desc_valid = 1, desc_done = 0, desc_clrtrig = 0, burst_done = 0;
  logic        grant, src_wrap, dst_wrap;
  logic [10:0] burst_len;
  logic [2:0]  prio;
  logic [2:0]  status;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  dma_trig_seq i_dma_trig_seq (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .periph_req(periph_req),
    .hw_trig(hw_trig), .sw_trig(sw_trig), .set_trig(set_trig), .clr_trig(clr_trig),
    .set_valid(set_valid), .desc_valid(desc_valid), .desc_done(desc_done),
    .desc_clrtrig(desc_clrtrig), .burst_done(burst_done), .grant(grant),
    .burst_len(burst_len), .src_wrap(src_wrap), .dst_wrap(dst_wrap),
    .prio(prio), .status(status)
  );

  function automatic logic [18:0] mk_cfg(input int req, hw, pol, lvl, bst, pw, sw, dw, pr);
    logic [18:0] w;
    w = '0;
    w[0] = req[0]; w[1] = hw[0]; w[4] = pol[0]; w[5] = lvl[0]; w[6] = bst[0];
    w[11:8] = pw[3:0]; w[14] = sw[0]; w[15] = dw[0]; w[18:16] = pr[2:0];
    return w;
  endfunction

  function automatic int exp_len(input int bst, input int pw);
    if (bst == 0) return 1;
    return 1 << ((pw > 10) ? 10 : pw);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // 0 sw, 1 set, 2 clr, 3 burst_done, 4 set_valid, 5 desc_done
  task automatic pulse(input int which);
    case (which)
      0: sw_trig = 1; 1: set_trig = 1; 2: clr_trig = 1;
      3: burst_done = 1; 4: set_valid = 1; default: desc_done = 1;
    endcase
    @(negedge clk);
    sw_trig = 0; set_trig = 0; clr_trig = 0;
    burst_done = 0; set_valid = 0; desc_done = 0;
  endtask

  task automatic do_reset();
    hw_trig = 0; periph_req = 0; desc_valid = 1; desc_clrtrig = 0;
    rst = 1; tick(2); rst = 0; tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1A2B);
    tick(2);
    chk("R1 grant in reset", int'(grant), 0);
    chk("R1 status in reset", int'(status), 0);
    chk("R1 len in reset", int'(burst_len), 0);
    chk("R1 prio/wrap in reset", int'({src_wrap, dst_wrap, prio}), 0);
    rst = 0; tick(1);
    chk("R1 grant after reset", int'(grant), 0);
    chk("R1 status after reset", int'(status), 0);

    // random sweep of software-triggered bursts
    for (int i = 0; i < 40; i++) begin
      int pw, bst, sw, dw, pr;
      pw = (i < 3) ? 15 - i * 3 : int'($urandom_range(0, 15));
      bst = (i < 3) ? 1 : int'($urandom_range(0, 1));
      sw = int'($urandom_range(0, 1)); dw = int'($urandom_range(0, 1));
      pr = int'($urandom_range(0, 7));
      cfg_word = mk_cfg(0, 0, 0, 0, bst, pw, sw, dw, pr);
      tick(1);
      pulse(0);
      chk("R2 flag after sw pulse", int'(status[2]), 1);
      chk("R2 no grant yet", int'(grant), 0);
      tick(1);
      chk("R2 grant", int'(grant), 1);
      chk("R3 burst length", int'(burst_len), exp_len(bst, pw));
      chk("R4 wrap and prio", int'({src_wrap, dst_wrap, prio}), (sw << 4) | (dw << 3) | pr);
      cfg_word = mk_cfg(0, 0, 0, 0, bst, pw, 1 - sw, 1 - dw, 7 - pr);
      tick(1);
      chk("R11 grant single cycle", int'(grant), 0);
      chk("R4 held while busy", int'({src_wrap, dst_wrap, prio}), (sw << 4) | (dw << 3) | pr);
      pulse(2);
      pulse(3);
      tick(1);
      chk("R10 cleared flag gives no grant", int'(grant), 0);
    end

    // peripheral request gating and busy hold
    do_reset();
    cfg_word = mk_cfg(1, 0, 0, 0, 1, 1, 0, 0, 0);
    pulse(0);
    for (int k = 0; k < 4; k++) begin
      tick(1);
      chk("R5 no grant without request", int'(grant), 0);
    end
    periph_req = 1;
    tick(1);
    chk("R5 grant after request", int'(grant), 1);
    chk("R5 len", int'(burst_len), 2);
    for (int k = 0; k < 5; k++) begin
      tick(1);
      chk("R11 no grant while busy", int'(grant), 0);
    end
    pulse(3);
    tick(1);
    chk("R9 burst mode regrant", int'(grant), 1);
    pulse(2); pulse(3); periph_req = 0;

    // valid gating
    do_reset();
    desc_valid = 0;
    cfg_word = mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
    pulse(0);
    tick(3);
    chk("R6 no grant without valid", int'(grant), 0);
    pulse(4);
    chk("R6 valid pending set", int'(status[0]), 1);
    chk("R6 grant not yet", int'(grant), 0);
    tick(1);
    chk("R6 grant with pending", int'(grant), 1);
    chk("R6 pending cleared", int'(status[0]), 0);
    pulse(3);
    tick(1);
    chk("R9 single consumed", int'(status[2]), 0);
    desc_valid = 1;

    // hardware edge mode
    do_reset();
    cfg_word = mk_cfg(0, 1, 1, 0, 0, 5, 0, 0, 0);
    tick(1);
    hw_trig = 1;
    tick(2);
    chk("R7 flag latency", int'(status[2]), 0);
    tick(1);
    chk("R7 rising edge sets flag", int'(status[2]), 1);
    tick(1);
    chk("R7 grant", int'(grant), 1);
    chk("R3 single len", int'(burst_len), 1);
    pulse(3);
    chk("R9 edge consumed", int'(status[2]), 0);
    tick(1);
    chk("R9 one grant per edge", int'(grant), 0);
    hw_trig = 0;
    tick(4);
    chk("R7 falling ignored", int'(status[2]), 0);
    chk("R7 falling no grant", int'(grant), 0);
    cfg_word = mk_cfg(0, 1, 0, 0, 0, 5, 0, 0, 0);
    hw_trig = 1;
    tick(4);
    chk("R7 rising ignored when low", int'(status[2]), 0);
    hw_trig = 0;
    tick(2);
    chk("R7 falling latency", int'(status[2]), 0);
    tick(1);
    chk("R7 falling sets flag", int'(status[2]), 1);
    tick(1);
    chk("R7 grant on falling", int'(grant), 1);
    pulse(3);

    // level mode
    do_reset();
    cfg_word = mk_cfg(0, 1, 1, 1, 1, 0, 0, 0, 0);
    tick(1);
    hw_trig = 1;
    tick(2);
    chk("R8 level latency", int'(status[2]), 0);
    tick(1);
    chk("R8 flag follows level", int'(status[2]), 1);
    tick(1);
    chk("R8 grant", int'(grant), 1);
    pulse(3);
    tick(1);
    chk("R8 regrant while held", int'(grant), 1);
    pulse(2);
    chk("R8 clear pulse ignored", int'(status[2]), 1);
    hw_trig = 0;
    tick(3);
    chk("R8 flag drops with level", int'(status[2]), 0);
    pulse(3);
    tick(1);
    chk("R8 no grant after drop", int'(grant), 0);
    pulse(0);
    chk("R8 sw pulse ignored", int'(status[2]), 0);
    tick(1);
    chk("R8 sw pulse no grant", int'(grant), 0);

    // clearing rules
    do_reset();
    cfg_word = mk_cfg(0, 0, 0, 0, 1, 2, 0, 0, 0);
    pulse(1);
    tick(1);
    chk("R2 grant from set pulse", int'(grant), 1);
    chk("R3 len 4", int'(burst_len), 4);
    pulse(5);
    chk("R10 done without clear keeps flag", int'(status[2]), 1);
    desc_clrtrig = 1;
    pulse(5);
    chk("R10 done with clear drops flag", int'(status[2]), 0);
    desc_clrtrig = 0;
    set_trig = 1; clr_trig = 1;
    tick(1);
    set_trig = 0; clr_trig = 0;
    chk("R10 set wins over clear", int'(status[2]), 1);
    pulse(3);
    tick(1);
    chk("R9 burst persistent regrant", int'(grant), 1);
    pulse(2);
    pulse(3);
    tick(1);
    chk("R10 clear pulse stops grants", int'(grant), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule